// File: doc/BRIEF.md
# Packet-Mode Radio State Sequencer

This block keeps the operating-mode control bits of a packet radio and steps the radio between four states: STANDBY, TUNE, TX and RX. A host writes a transmit-enable, a receive-enable and a PLL-enable bit into a first control register, and a multi-packet receive bit into a second one. The resulting state follows from those bits, with transmit taking priority over receive, receive over tune, and standby when nothing is enabled.

When a packet has gone out, the packet-sent pulse clears the transmit-enable bit, and the radio falls back to whatever state the remaining bits select. When a good packet has come in, the packet-valid pulse clears the receive-enable bit in the same way, unless multi-packet receive is on, in which case the radio stays in RX and the host decides what comes next. Both events are latched in sticky status bits that the host reads and clears, and any set bit raises an interrupt line.

Top module: `radio_seq_top`

## Requirements
- R1: After reset the state output is 00 (STANDBY), both control registers read 0, the status register reads 0 and irq_o is low.
- R2: The state output uses 00 STANDBY, 01 TUNE, 10 TX, 11 RX. It is decoded from the control bits with priority transmit-enable (address 0 bit 3) over receive-enable (address 0 bit 2) over PLL-enable (address 0 bit 1), else STANDBY, and it takes its new value at the same clock edge that loads a host write.
- R3: A packet-sent pulse while in TX clears transmit-enable, and the next state is the one the remaining bits select (RX if receive-enable is set, else TUNE if PLL-enable is set, else STANDBY).
- R4: A packet-valid pulse while in RX with the multi-packet bit (address 1 bit 4) clear clears receive-enable, and the next state is TUNE if PLL-enable is set, else STANDBY.
- R5: A packet-valid pulse while in RX with the multi-packet bit set leaves receive-enable set and the state at RX.
- R6: A packet-sent pulse outside TX and a packet-valid pulse outside RX change neither the control bits, the state nor the status register.
- R7: A host write that clears the active enable bit moves the state at once, at that edge, to the state selected by the bits that remain.
- R8: The status register (address 2) holds bit 0 for an accepted packet-sent event and bit 1 for an accepted packet-valid event (whether or not the radio stayed in RX); a read of address 2 returns the current bits and clears them at that edge, except that an event accepted in the same cycle leaves its bit set.
- R9: irq_o is high exactly when a status bit is set.
- R10: When a host write to address 0 and a completion event fall in the same cycle, the written control value is what the register holds afterwards; the status bit is still set. Unused bits read 0 and writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address (0 mode control, 1 receive control) |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe; a read of address 2 clears the status |
| rd_addr | input | 2 | Host read address (0, 1 control, 2 status) |
| rd_data | output | 8 | Read data for rd_addr, combinational |
| pkt_sent_i | input | 1 | Single-cycle packet-sent event |
| pkt_valid_i | input | 1 | Single-cycle packet-valid event |
| state_o | output | 2 | Current radio state |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
The bench aims at the fall-back after an automatic exit with several enable bits set at once: a design that went straight to STANDBY would miss RX after a transmit with receive still enabled, or TUNE with the PLL bit set. It drives packet-valid with the multi-packet bit in both settings, so a design that ignored the bit would drop out of RX, and it sends events in the wrong state, where a design that did not gate them would set status or clear bits. It also lines up a status read with a new event and a host write with an event in one cycle, where a wrong priority would lose the event or the written value.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  typedef enum logic [1:0] {
    ST_STBY = 2'b00,
    ST_TUNE = 2'b01,
    ST_TX   = 2'b10,
    ST_RX   = 2'b11
  } rs_state_e;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
    logic pll_en;
    logic multi_pkt;
  } rs_ctrl_t;

  // Priority decode of the enable bits into a radio state.
  function automatic rs_state_e rs_pick(input rs_ctrl_t c);
    rs_state_e s;
    if (c.tx_en)       s = ST_TX;
    else if (c.rx_en)  s = ST_RX;
    else if (c.pll_en) s = ST_TUNE;
    else               s = ST_STBY;
    return s;
  endfunction

endpackage

// File: rtl/radio_seq_rst_sync.sv
module radio_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/radio_seq_regs.sv
module radio_seq_regs
  import radio_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int MODE_ADDR  = 0,
  parameter int RXC_ADDR   = 1,
  parameter int TX_BIT     = 3,
  parameter int RX_BIT     = 2,
  parameter int PLL_BIT    = 1,
  parameter int MPK_BIT    = 4
) (
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_done,
  input  logic              rx_done,
  output rs_ctrl_t          ctrl_q,
  output rs_ctrl_t          ctrl_d
);

  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] RXC_A  = ADDR_W'(RXC_ADDR);

  logic wr_mode, wr_rxc, ld_en;

  always_comb begin
    wr_mode = wr_en && (wr_addr == MODE_A);
    wr_rxc  = wr_en && (wr_addr == RXC_A);
    ld_en   = wr_mode || wr_rxc || tx_done || rx_done;

    ctrl_d = ctrl_q;
    // Completion events clear their own enable bit.
    if (tx_done) ctrl_d.tx_en = 1'b0;
    if (rx_done) ctrl_d.rx_en = 1'b0;
    // A host write to the same register overrides the event (R10).
    if (wr_mode) begin
      ctrl_d.tx_en  = wr_data[TX_BIT];
      ctrl_d.rx_en  = wr_data[RX_BIT];
      ctrl_d.pll_en = wr_data[PLL_BIT];
    end
    if (wr_rxc) ctrl_d.multi_pkt = wr_data[MPK_BIT];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   ctrl_q <= '0;
    else if (ld_en) ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/radio_seq_fsm.sv
module radio_seq_fsm
  import radio_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_s_n,
  input  rs_ctrl_t  ctrl_q,
  input  rs_ctrl_t  ctrl_d,
  input  logic      pkt_sent,
  input  logic      pkt_valid,
  output rs_state_e state_q,
  output logic      sent_acc,
  output logic      valid_acc,
  output logic      tx_done,
  output logic      rx_done
);

  rs_state_e state_d;

  always_comb begin
    // Events count only in the state they belong to (R6).
    sent_acc  = pkt_sent  && (state_q == ST_TX);
    valid_acc = pkt_valid && (state_q == ST_RX);
    tx_done   = sent_acc;
    rx_done   = valid_acc && !ctrl_q.multi_pkt;
    state_d   = rs_pick(ctrl_d);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) state_q <= ST_STBY;
    else          state_q <= state_d;
  end

endmodule

// File: rtl/radio_seq_status.sv
module radio_seq_status #(
  parameter int NUM_EV = 2
) (
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic [NUM_EV-1:0] ev_acc,
  input  logic              rd_clr,
  output logic [NUM_EV-1:0] stat_q,
  output logic              irq
);

  logic [NUM_EV-1:0] stat_d;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    always_comb begin
      stat_d[i] = (stat_q[i] && !rd_clr) || ev_acc[i];
    end

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) stat_q[i] <= 1'b0;
      else          stat_q[i] <= stat_d[i];
    end

    // R8
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      ev_acc[i] |=> stat_q[i]);

    // R8
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (rd_clr && !ev_acc[i]) |=> !stat_q[i]);

    // R8
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (!rd_clr && !ev_acc[i]) |=> $stable(stat_q[i]));
  end

  assign irq = |stat_q;

endmodule

// File: rtl/radio_seq_top.sv
module radio_seq_top
  import radio_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int MODE_ADDR = 0,
  parameter int RXC_ADDR  = 1,
  parameter int STAT_ADDR = 2,
  parameter int TX_BIT    = 3,
  parameter int RX_BIT    = 2,
  parameter int PLL_BIT   = 1,
  parameter int MPK_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pkt_sent_i,
  input  logic              pkt_valid_i,
  output logic [1:0]        state_o,
  output logic              irq_o
);

  localparam int NUM_EV = 2;
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] RXC_A  = ADDR_W'(RXC_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic              rst_s_n;
  rs_ctrl_t          ctrl_q, ctrl_d;
  rs_state_e         state_q;
  logic              sent_acc, valid_acc, tx_done, rx_done;
  logic [NUM_EV-1:0] stat_q;
  logic              rd_clr;

  radio_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  radio_seq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .RXC_ADDR(RXC_ADDR),
    .TX_BIT(TX_BIT), .RX_BIT(RX_BIT), .PLL_BIT(PLL_BIT), .MPK_BIT(MPK_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tx_done (tx_done),
    .rx_done (rx_done),
    .ctrl_q  (ctrl_q),
    .ctrl_d  (ctrl_d)
  );

  radio_seq_fsm u_fsm (
    .clk       (clk),
    .rst_s_n   (rst_s_n),
    .ctrl_q    (ctrl_q),
    .ctrl_d    (ctrl_d),
    .pkt_sent  (pkt_sent_i),
    .pkt_valid (pkt_valid_i),
    .state_q   (state_q),
    .sent_acc  (sent_acc),
    .valid_acc (valid_acc),
    .tx_done   (tx_done),
    .rx_done   (rx_done)
  );

  assign rd_clr = rd_en && (rd_addr == STAT_A);

  radio_seq_status #(.NUM_EV(NUM_EV)) u_stat (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .ev_acc  ({valid_acc, sent_acc}),
    .rd_clr  (rd_clr),
    .stat_q  (stat_q),
    .irq     (irq_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == MODE_A) begin
      rd_data[TX_BIT]  = ctrl_q.tx_en;
      rd_data[RX_BIT]  = ctrl_q.rx_en;
      rd_data[PLL_BIT] = ctrl_q.pll_en;
    end else if (rd_addr == RXC_A) begin
      rd_data[MPK_BIT] = ctrl_q.multi_pkt;
    end else if (rd_addr == STAT_A) begin
      rd_data[NUM_EV-1:0] = stat_q;
    end
  end

  assign state_o = state_q;

  logic wr_mode;
  assign wr_mode = wr_en && (wr_addr == MODE_A);

  // R3
  tx_exit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_o == ST_TX && pkt_sent_i && !wr_mode) |=> (state_o != ST_TX));

  // R4
  rx_exit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_o == ST_RX && pkt_valid_i && !ctrl_q.multi_pkt && !wr_mode)
      |=> (state_o == ST_TUNE || state_o == ST_STBY));

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_o == ST_RX && pkt_valid_i && ctrl_q.multi_pkt && !wr_mode) |=> (state_o == ST_RX));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((state_o == ST_STBY || state_o == ST_TUNE) && !wr_mode) |=> $stable(state_o));

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(irq_o) |-> ($past(sent_acc) || $past(valid_acc)));

endmodule

// File: tb/radio_seq_top_tb.sv
module radio_seq_top_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       pkt_sent_i, pkt_valid_i;
  logic [1:0] state_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit m_tx, m_rx, m_pll, m_mpk, m_s, m_v;

  radio_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pkt_sent_i(pkt_sent_i), .pkt_valid_i(pkt_valid_i),
    .state_o(state_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_state();
    if (m_tx)       return 8'd2;
    else if (m_rx)  return 8'd3;
    else if (m_pll) return 8'd1;
    else            return 8'd0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {4'b0, m_tx, m_rx, m_pll, 1'b0};
      2'd1:    return {3'b0, m_mpk, 4'b0};
      2'd2:    return {6'b0, m_v, m_s};
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus; checks read data before the edge and state/irq after it.
  task automatic step(input bit we, input logic [1:0] wa, input logic [7:0] wd,
                      input bit re, input logic [1:0] ra, input bit s, input bit v,
                      input string tag);
    bit acc_s, acc_v, clr;
    logic [7:0] st;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra; pkt_sent_i = s; pkt_valid_i = v;
    #1;
    if (re) chk((ra == 2'd2) ? "R8" : "R10", "read data", rd_data, exp_rd(ra));
    st    = exp_state();
    acc_s = s && (st == 8'd2);
    acc_v = v && (st == 8'd3);
    clr   = re && (ra == 2'd2);
    if (acc_s) m_tx = 1'b0;
    if (acc_v && !m_mpk) m_rx = 1'b0;
    if (we && wa == 2'd0) begin m_tx = wd[3]; m_rx = wd[2]; m_pll = wd[1]; end
    if (we && wa == 2'd1) m_mpk = wd[4];
    m_s = (m_s && !clr) || acc_s;
    m_v = (m_v && !clr) || acc_v;
    @(posedge clk);
    #1;
    chk(tag, "state", {6'b0, state_o}, exp_state());
    chk("R9", "irq", {7'b0, irq_o}, {7'b0, m_s | m_v});
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_en = 0; rd_addr = 0;
    pkt_sent_i = 0; pkt_valid_i = 0;
    {m_tx, m_rx, m_pll, m_mpk, m_s, m_v} = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    chk("R1", "state", {6'b0, state_o}, 8'd0);
    chk("R1", "irq", {7'b0, irq_o}, 8'd0);
    step(0, 0, 0, 1, 2'd0, 0, 0, "R1");
    step(0, 0, 0, 1, 2'd1, 0, 0, "R1");
    step(0, 0, 0, 1, 2'd2, 0, 0, "R1");

    // R2 priority: tx+rx+pll -> TX
    step(1, 2'd0, 8'h0E, 0, 0, 0, 0, "R2");
    chk("R2", "tx priority", {6'b0, state_o}, 8'd2);
    // R3 sent -> RX since rx_en remains
    step(0, 0, 0, 0, 0, 1, 0, "R3");
    chk("R3", "fall to rx", {6'b0, state_o}, 8'd3);
    // R4 valid with mpk clear -> TUNE
    step(0, 0, 0, 0, 0, 0, 1, "R4");
    chk("R4", "fall to tune", {6'b0, state_o}, 8'd1);
    chk("R9", "irq after events", {7'b0, irq_o}, 8'd1);
    // R8 read returns both bits then clears
    step(0, 0, 0, 1, 2'd2, 0, 0, "R8");
    chk("R8", "cleared irq", {7'b0, irq_o}, 8'd0);
    // R6 events in TUNE ignored
    step(0, 0, 0, 0, 0, 1, 1, "R6");
    chk("R6", "tune ignores events", {7'b0, irq_o}, 8'd0);
    step(0, 0, 0, 1, 2'd0, 0, 0, "R6");

    // R5 multi-packet hold
    step(1, 2'd1, 8'h10, 0, 0, 0, 0, "R5");
    step(1, 2'd0, 8'h04, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 1, "R5");
    chk("R5", "stay rx", {6'b0, state_o}, 8'd3);
    step(0, 0, 0, 1, 2'd0, 0, 0, "R5");
    // R6 sent in RX ignored
    step(0, 0, 0, 1, 2'd2, 1, 0, "R6");
    // R7 host clears rx -> STANDBY at once
    step(1, 2'd0, 8'h00, 0, 0, 0, 0, "R7");
    chk("R7", "forced exit", {6'b0, state_o}, 8'd0);
    // R6 events in STANDBY ignored
    step(0, 0, 0, 0, 0, 1, 1, "R6");

    // R10 write with event same cycle: write wins, status set
    step(1, 2'd0, 8'h08, 0, 0, 0, 0, "R2");
    step(1, 2'd0, 8'h0A, 0, 0, 1, 0, "R10");
    chk("R10", "write wins", {6'b0, state_o}, 8'd2);
    chk("R10", "event still latched", {7'b0, irq_o}, 8'd1);
    // R10 writes to status address ignored
    step(1, 2'd2, 8'hFF, 1, 2'd2, 0, 0, "R10");
    // R8 read together with new event keeps bit
    step(0, 0, 0, 1, 2'd2, 1, 0, "R8");
    chk("R8", "set beats clear", {7'b0, irq_o}, 8'd1);
    step(0, 0, 0, 1, 2'd2, 0, 0, "R8");
    // R3 sent with pll only -> TUNE, then clear
    step(0, 0, 0, 0, 0, 0, 0, "R3");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      bit we, re, s, v;
      logic [1:0] wa, ra;
      logic [7:0] wd;
      string tag;
      logic [7:0] st;
      we = ($urandom % 5) == 0;
      wa = 2'($urandom % 4);
      wd = 8'($urandom);
      re = ($urandom % 4) == 0;
      ra = 2'($urandom % 4);
      s  = ($urandom % 4) == 0;
      v  = ($urandom % 4) == 0;
      st = exp_state();
      if (we && wa == 2'd0)             tag = "R7";
      else if (s && st == 8'd2)         tag = "R3";
      else if (v && st == 8'd3 && m_mpk) tag = "R5";
      else if (v && st == 8'd3)         tag = "R4";
      else if (we)                      tag = "R2";
      else                              tag = "R6";
      step(we, wa, wd, re, ra, s, v, tag);
    end
    idle("R6");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule